// File: doc/BRIEF.md
# Keyed Watchdog and Software-Reset Controller

This block sits beside the CPU of a small microcontroller and owns every reset it can start itself. A free-running counter times out unless the CPU keeps reloading it. The CPU talks to the block through a single write-only restart register. Writes to it are accepted only as two-byte key pairs. One pair reloads the watchdog, and a second pair asks for a software reset. Any other pair counts as a fault and starts a reset at once.

Every reset the block starts is an internal pulse of fixed length, 49 clock cycles by default. Each reset also sets sticky cause flags, which the CPU reads after it restarts. The pulse can also drive the external reset pin. The pin's active level is selectable, and a disable control keeps the pin undriven while the internal reset still happens. The timeout period is picked from four power-of-two lengths.

Top module: `wdkey_rst_ctrl`

## Requirements
- R1: Writing 0x1E and then 0xE1 to the restart register reloads the watchdog. While such a pair arrives within every period, no reset is produced and no flag is set.
- R2: With no reload, a reset pulse starts 2^(6+psel) cycles after the last reload. It sets flag_wdt and leaves flag_sw unchanged. The count is measured from the write of the second key byte to the first cycle the pulse is high.
- R3: Writing 0x5A and then 0xA5 starts a reset pulse in the cycle after the second byte. It sets flag_sw and leaves flag_wdt unchanged.
- R4: A reset pulse starts in the cycle after an invalid byte, and that byte sets both flag_wdt and flag_sw. An invalid byte is either a first byte other than 0x1E or 0x5A, or a second byte that does not complete the pair its first byte began.
- R5: Every reset pulse on int_rst is high for exactly 49 consecutive cycles.
- R6: While int_rst is high and pin_dis is 0, rst_pin_oe is 1 and rst_pin_o equals pin_pol, where 1 means active-high. In every other case rst_pin_oe is 0 and rst_pin_o equals the inverse of pin_pol.
- R7: Setting pin_dis to 1 does not stop or shorten the internal pulse on int_rst.
- R8: The cause flags are sticky and survive the pulses this block generates. A cycle with flag_clr high clears both flags; a cause that arrives in the same cycle still sets its flag. Driving rst_n low clears both flags at once.
- R9: A reset cause that arrives while a pulse is active does not restart or lengthen that pulse, but its flag is still set.
- R10: After a pulse ends, the watchdog restarts from zero. The next timeout pulse starts 2^(6+psel) cycles after the first low cycle of int_rst.
- R11: During and after rst_n low, int_rst, flag_wdt, flag_sw and rst_pin_oe are 0.
- R12: After each completed pair the key checker waits for a new first byte. A valid first byte on its own starts no reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| key_we | input | 1 | Write strobe for the restart register |
| key_data | input | 8 | Byte written to the restart register |
| psel | input | PSEL_W | Timeout select: period is 2^(BASE_LOG2+psel) cycles |
| flag_clr | input | 1 | CPU write that clears both cause flags |
| pin_dis | input | 1 | 1 keeps the external reset pin undriven |
| pin_pol | input | 1 | Active level of the external reset pin (1 = high) |
| int_rst | output | 1 | Internal reset pulse |
| rst_pin_o | output | 1 | Value for the external reset pin driver |
| rst_pin_oe | output | 1 | Output enable for the external reset pin driver |
| flag_wdt | output | 1 | Sticky watchdog-overflow cause flag |
| flag_sw | output | 1 | Sticky software-reset cause flag |

## Verification
The key checker is exercised with the two exact key pairs and with random pairs. Some random pairs begin with a valid byte and end with a random one, and some begin with an invalid byte. This separates a fault caught on the first byte from one caught on the second, and confirms that a valid first byte alone does nothing. Regular reloads and deliberate silence, at two period settings, check the timeout count from the last reload and from the end of a pulse. A fault key written inside a running pulse tests that the pulse is not lengthened while the flag is still set. Each pulse is also tried with pin polarity high and low and with the pin disabled, to separate the pin drive from the internal reset.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam logic [7:0] KICK_LO = 8'h1E;
  localparam logic [7:0] KICK_HI = 8'hE1;
  localparam logic [7:0] SWR_LO  = 8'h5A;
  localparam logic [7:0] SWR_HI  = 8'hA5;

  typedef enum logic {PAIR_FIRST = 1'b0, PAIR_SECOND = 1'b1} pair_state_e;

  typedef struct packed {
    logic kick;
    logic swreq;
    logic bad;
  } key_evt_t;
endpackage

// File: rtl/wdk_key_check.sv
module wdk_key_check
  import wdk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_we,
  input  logic [7:0] key_data,
  output key_evt_t   evt_o
);
  pair_state_e state_q, state_d;
  logic [7:0]  first_q, first_d;

  always_comb begin
    state_d = state_q;
    first_d = first_q;
    evt_o   = '0;
    if (key_we) begin
      if (state_q == PAIR_FIRST) begin
        if (key_data == KICK_LO || key_data == SWR_LO) begin
          state_d = PAIR_SECOND;
          first_d = key_data;
        end else begin
          evt_o.bad = 1'b1;
        end
      end else begin
        state_d = PAIR_FIRST;
        if (first_q == KICK_LO && key_data == KICK_HI) evt_o.kick = 1'b1;
        else if (first_q == SWR_LO && key_data == SWR_HI) evt_o.swreq = 1'b1;
        else evt_o.bad = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PAIR_FIRST;
      first_q <= '0;
    end else if (key_we) begin
      state_q <= state_d;
      first_q <= first_d;
    end
  end

  // R12
  pair_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && state_q == PAIR_SECOND) |=> (state_q == PAIR_FIRST));

  // R4
  first_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && state_q == PAIR_FIRST && !evt_o.bad) |=> (state_q == PAIR_SECOND));
endmodule

// File: rtl/wdk_timer.sv
module wdk_timer #(
  parameter int BASE_LOG2 = 6,
  parameter int PSEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              reload,
  input  logic [PSEL_W-1:0] psel,
  output logic              timeout_o
);
  localparam int CNT_W = BASE_LOG2 + (1 << PSEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic [CNT_W:0]   span;

  always_comb begin
    span      = (CNT_W+1)'(1) << (BASE_LOG2 + int'(psel));
    limit     = CNT_W'(span - 1'b1);
    timeout_o = !hold && !reload && (cnt_q >= limit);
    if (hold || reload || timeout_o) cnt_d = '0;
    else                             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0));

  // R1
  reload_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !hold) |=> !timeout_o);
endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
  parameter int PULSE_LEN = 49
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic active_o
);
  localparam int CW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
  localparam logic [CW-1:0] LOAD_V = CW'(PULSE_LEN - 1);

  logic          active_q, active_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (start_i && !active_q) begin
      active_d = 1'b1;
      cnt_d    = LOAD_V;
    end else if (active_q) begin
      if (cnt_q == '0) active_d = 1'b0;
      else             cnt_d    = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign active_o = active_q;

  // R5
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && cnt_q != '0) |=> (active_q && cnt_q == $past(cnt_q) - 1'b1));

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && start_i) |=> (!active_q || cnt_q != LOAD_V));
endmodule

// File: rtl/wdkey_rst_ctrl.sv
module wdkey_rst_ctrl
  import wdk_pkg::*;
#(
  parameter int BASE_LOG2 = 6,
  parameter int PSEL_W    = 2,
  parameter int PULSE_LEN = 49
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_we,
  input  logic [7:0]        key_data,
  input  logic [PSEL_W-1:0] psel,
  input  logic              flag_clr,
  input  logic              pin_dis,
  input  logic              pin_pol,
  output logic              int_rst,
  output logic              rst_pin_o,
  output logic              rst_pin_oe,
  output logic              flag_wdt,
  output logic              flag_sw
);
  logic [1:0] sync_q;
  logic       rst_sync_n;
  key_evt_t   evt;
  logic       timeout;
  logic       start_req;
  logic       wdt_d, sw_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  wdk_key_check u_keys (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .key_we   (key_we),
    .key_data (key_data),
    .evt_o    (evt)
  );

  wdk_timer #(.BASE_LOG2(BASE_LOG2), .PSEL_W(PSEL_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .hold      (int_rst),
    .reload    (evt.kick),
    .psel      (psel),
    .timeout_o (timeout)
  );

  assign start_req = evt.swreq | evt.bad | timeout;

  wdk_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_i  (start_req),
    .active_o (int_rst)
  );

  always_comb begin
    wdt_d = flag_clr ? 1'b0 : flag_wdt;
    sw_d  = flag_clr ? 1'b0 : flag_sw;
    if (timeout || evt.bad)   wdt_d = 1'b1;
    if (evt.swreq || evt.bad) sw_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flag_wdt <= 1'b0;
      flag_sw  <= 1'b0;
    end else begin
      flag_wdt <= wdt_d;
      flag_sw  <= sw_d;
    end
  end

  assign rst_pin_oe = int_rst & ~pin_dis;
  assign rst_pin_o  = rst_pin_oe ? pin_pol : ~pin_pol;

  // R6
  pin_drive_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_pin_oe |-> (int_rst && rst_pin_o == pin_pol));

  // R3
  sw_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    evt.swreq |=> (flag_sw && int_rst));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_wdt && !flag_clr) |=> flag_wdt);
endmodule

// File: tb/wdkey_rst_ctrl_bench.sv
`timescale 1ns/1ps
module wdkey_rst_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n, key_we, flag_clr, pin_dis, pin_pol;
  logic [7:0] key_data;
  logic [1:0] psel;
  logic       int_rst, rst_pin_o, rst_pin_oe, flag_wdt, flag_sw;

  int tests = 0;
  int fails = 0;
  int cur_len = 0;
  int last_len = 0;
  int rises = 0;
  logic prev_rst = 1'b0;

  always #2.5 clk = ~clk;

  wdkey_rst_ctrl u_wdkey_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_data(key_data),
    .psel(psel), .flag_clr(flag_clr), .pin_dis(pin_dis), .pin_pol(pin_pol),
    .int_rst(int_rst), .rst_pin_o(rst_pin_o), .rst_pin_oe(rst_pin_oe),
    .flag_wdt(flag_wdt), .flag_sw(flag_sw)
  );

  always @(negedge clk) begin
    if (int_rst) begin
      cur_len = cur_len + 1;
      if (!prev_rst) rises = rises + 1;
    end else begin
      if (cur_len != 0) last_len = cur_len;
      cur_len = 0;
    end
    prev_rst = int_rst;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    key_we = 1'b1; key_data = b;
    @(negedge clk);
    key_we = 1'b0;
  endtask

  task automatic kick();
    wr(8'h1E); wr(8'hE1);
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic wait_low();
    while (int_rst) @(negedge clk);
  endtask

  task automatic check_len(input string tag);
    #1;
    chk(last_len == 49, tag, last_len, 49);
  endtask

  // 0 = reload, 1 = software reset, 2 = fault
  function automatic int classify(input logic [7:0] a, input logic [7:0] b);
    if (a == 8'h1E && b == 8'hE1) return 0;
    if (a == 8'h5A && b == 8'hA5) return 1;
    return 2;
  endfunction

  function automatic int period(input logic [1:0] s);
    return 1 << (6 + int'(s));
  endfunction

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    int cls;
    int seed;
    logic [7:0] b1, b2;
    seed = $urandom(32'd20240);
    rst_n = 1'b0; key_we = 1'b0; key_data = 8'h00; psel = 2'd0;
    flag_clr = 1'b0; pin_dis = 1'b0; pin_pol = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(int_rst == 0 && flag_wdt == 0 && flag_sw == 0, "R11 outputs in reset",
        {int_rst, flag_wdt, flag_sw}, 0);
    chk(rst_pin_oe == 0 && rst_pin_o == 0, "R11 pin idle in reset", {rst_pin_oe, rst_pin_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 regular reloads keep the block quiet
    for (int i = 0; i < 8; i++) begin
      repeat (50) @(negedge clk);
      kick();
    end
    chk(rises == 0, "R1 no pulse with reloads", rises, 0);
    chk(flag_wdt == 0 && flag_sw == 0, "R1 no flags", {flag_wdt, flag_sw}, 0);

    // R2 timeout after silence, psel=0
    kick();
    n = 0;
    while (!int_rst && n < 2000) begin @(negedge clk); n++; end
    chk(n == period(2'd0), "R2 timeout period psel0", n, period(2'd0));
    chk(flag_wdt == 1 && flag_sw == 0, "R2 watchdog flag only", {flag_wdt, flag_sw}, 2);
    // R6 pin drive active-high
    chk(rst_pin_oe == 1 && rst_pin_o == 1, "R6 pin driven high", {rst_pin_oe, rst_pin_o}, 3);
    wait_low();
    chk(rst_pin_oe == 0 && rst_pin_o == 0, "R6 pin released", {rst_pin_oe, rst_pin_o}, 0);
    // R10 restart after pulse end
    n = 0;
    while (!int_rst && n < 2000) begin @(negedge clk); n++; end
    chk(n == period(2'd0), "R10 restart after pulse psel0", n, period(2'd0));
    check_len("R5 timeout pulse width");
    psel = 2'd1;
    wait_low();
    n = 0;
    while (!int_rst && n < 2000) begin @(negedge clk); n++; end
    chk(n == period(2'd1), "R10 restart after pulse psel1", n, period(2'd1));
    wait_low();
    // R8 sticky across own pulses
    chk(flag_wdt == 1, "R8 flag survives pulse", flag_wdt, 1);
    kick();
    clear_flags();
    chk(flag_wdt == 0 && flag_sw == 0, "R8 flag_clr clears", {flag_wdt, flag_sw}, 0);

    // R3 software reset key, active-low pin
    psel = 2'd3;
    pin_pol = 1'b0;
    wr(8'h5A);
    chk(int_rst == 0, "R12 first byte alone", int_rst, 0);
    wr(8'hA5);
    chk(int_rst == 1, "R3 pulse after key", int_rst, 1);
    chk(flag_sw == 1 && flag_wdt == 0, "R3 software flag only", {flag_wdt, flag_sw}, 1);
    chk(rst_pin_oe == 1 && rst_pin_o == 0, "R6 pin driven low", {rst_pin_oe, rst_pin_o}, 2);
    wait_low();
    check_len("R5 software pulse width");
    chk(rst_pin_oe == 0 && rst_pin_o == 1, "R6 active-low idle", {rst_pin_oe, rst_pin_o}, 1);

    // R7 pin disabled: internal reset still occurs
    pin_dis = 1'b1;
    wr(8'h1E); wr(8'hA5);
    chk(int_rst == 1, "R7 internal pulse with pin off", int_rst, 1);
    chk(rst_pin_oe == 0 && rst_pin_o == 1, "R7 pin undriven", {rst_pin_oe, rst_pin_o}, 1);
    chk(flag_wdt == 1 && flag_sw == 1, "R4 wrong second byte flags", {flag_wdt, flag_sw}, 3);
    wait_low();
    check_len("R7 pulse width with pin off");
    pin_dis = 1'b0;
    pin_pol = 1'b1;

    // R9 fault inside a running pulse
    kick();
    clear_flags();
    wr(8'h5A); wr(8'hA5);
    repeat (10) @(negedge clk);
    wr(8'h00);
    chk(flag_wdt == 1, "R9 flag recorded during pulse", flag_wdt, 1);
    wait_low();
    check_len("R9 pulse not extended");

    // R4 / R12 random pairs
    for (int i = 0; i < 40; i++) begin
      wait_low();
      kick();
      clear_flags();
      b1 = ($urandom % 2 == 0) ? (($urandom % 2 == 0) ? 8'h1E : 8'h5A) : 8'($urandom);
      if (b1 != 8'h1E && b1 != 8'h5A) begin
        wr(b1);
        chk(int_rst == 1 && flag_wdt == 1 && flag_sw == 1, "R4 bad first byte",
            {int_rst, flag_wdt, flag_sw}, 7);
      end else begin
        if ($urandom % 2 == 0) b2 = (b1 == 8'h1E) ? 8'hE1 : 8'hA5;
        else                   b2 = 8'($urandom);
        wr(b1);
        chk(int_rst == 0, "R12 valid first byte no pulse", int_rst, 0);
        wr(b2);
        cls = classify(b1, b2);
        if (cls == 0)
          chk(int_rst == 0 && flag_wdt == 0 && flag_sw == 0, "R1 random reload",
              {int_rst, flag_wdt, flag_sw}, 0);
        else if (cls == 1)
          chk(int_rst == 1 && flag_wdt == 0 && flag_sw == 1, "R3 random software key",
              {int_rst, flag_wdt, flag_sw}, 5);
        else
          chk(int_rst == 1 && flag_wdt == 1 && flag_sw == 1, "R4 bad second byte",
              {int_rst, flag_wdt, flag_sw}, 7);
      end
    end
    wait_low();

    // R12 back-to-back reload pairs stay paired
    kick(); kick(); kick();
    chk(int_rst == 0, "R12 consecutive pairs", int_rst, 0);

    // R8 power-on reset clears flags
    wr(8'h77);
    wait_low();
    chk(flag_wdt == 1 && flag_sw == 1, "R8 flags set before POR", {flag_wdt, flag_sw}, 3);
    rst_n = 1'b0;
    #1;
    chk(flag_wdt == 0 && flag_sw == 0 && int_rst == 0, "R8 POR clears flags",
        {int_rst, flag_wdt, flag_sw}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule